// File: doc/BRIEF.md
# Video Automatic Gain Controller

This block closes the digital side of a gain loop for one composite video channel. It receives 10-bit converter samples and a separate luma sample stream. Strobes mark the sync tip, the color burst and the active picture. Over each line it records the largest sample inside every window. This gives four amplitude figures: sync height, burst amplitude, composite peak and luma peak.

When a line ends, the block compares each enabled figure with a fixed target and settles on the most restrictive result. It then moves a 12-bit fine gain code. That code carries into and borrows from a 4-bit coarse gain code, and both codes drive an external analog amplifier. Coarse code 0 is the lowest gain (-6 dB, 2.0 Vpp full scale) and code 15 is the highest gain (+6 dB, 0.5 Vpp full scale).

Clipping cuts the gain at once and by a large step. Gain rises only by a programmable step, and only after a programmable number of lines without clipping. A small synchronous register port holds the loop enable, the reference enables, the rise speed, the rise delay and a manual gain. The same port reads back the gain that is driving the amplifier.

Top module: `vagc_top`

## Requirements
- R1: After reset the loop is disabled and all reference enables are clear. The rise speed is 1 and the rise delay is 0. The manual gain is coarse 8 / fine 2048, and the outputs show that gain.
- R2: The register port is written when `reg_we` is high and read one cycle after `reg_addr` is presented. The addresses are: 0 = control, where bit 0 is the loop enable and bits 1..4 enable sync, burst, composite and luma in that order; 1 = rise speed, 8 bits; 2 = rise delay, 8 bits; 3 = manual gain, with coarse in bits 15:12 and fine in bits 11:0; 4 = gain in use, read only, in the same layout as address 3.
- R3: While the loop is disabled, the outputs take the manual gain two cycles after it is written, and line events leave the gain unchanged.
- R4: Sync, burst and composite are the maximum of `sample` while `sync_win`, `burst_win` and `active_win` are high, in that order. Luma is the maximum of `luma` while `active_win` is high. Samples outside the windows are ignored. All four are cleared at `line_end`, and the gain changes only in the cycle after a `line_end` pulse.
- R5: If any enabled figure is 1023 or higher, the fine code drops by 512 at that line end.
- R6: If no enabled figure clips but any one exceeds its target, the fine code drops by 16. The targets are sync 200, burst 150, composite 1000 and luma 900.
- R7: If every enabled figure is below its target and the quiet-line count is at least the rise delay, the fine code rises by the rise speed. In every other case the gain holds. A figure equal to its target also holds the gain.
- R8: The quiet-line count starts at 0. It rises by one on every enabled line without clipping and saturates at 255. A clipping line clears it, and disabling the loop clears it.
- R9: If the fine result would exceed 4095, coarse rises by one and fine becomes 2048. If the fine result would fall below 0, coarse drops by one and fine becomes 2048.
- R10: At coarse 15 an overflow leaves fine at 4095. At coarse 0 an underflow leaves fine at 0.
- R11: A disabled reference has no effect on the decision. With no references enabled, the gain and the quiet-line count hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample | input | 10 | Composite converter sample |
| luma | input | 10 | Luma sample after separation |
| sync_win | input | 1 | Sync tip window |
| burst_win | input | 1 | Color burst window |
| active_win | input | 1 | Active picture window |
| line_end | input | 1 | One-cycle end-of-line strobe |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| coarse_gain | output | 4 | Coarse gain code to the amplifier |
| fine_gain | output | 12 | Fine gain code to the amplifier |

## Verification
The assertions assume that `line_end` is a single-cycle pulse and that no window is high in the same cycle. Without that, a line could close while a peak is still being captured. They also assume that the gain changes only through the loop or the manual register. The stimulus builds every line the same way: three fixed window phases, then gaps that carry full-scale junk samples, then the end-of-line pulse on a cycle by itself. Register writes are made only between lines.

// File: rtl/vagc_pkg.sv
package vagc_pkg;
  localparam logic [2:0] ADDR_CTRL   = 3'd0;
  localparam logic [2:0] ADDR_SPEED  = 3'd1;
  localparam logic [2:0] ADDR_DELAY  = 3'd2;
  localparam logic [2:0] ADDR_MANUAL = 3'd3;
  localparam logic [2:0] ADDR_GAIN   = 3'd4;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2,
    STEP_CLIP = 2'd3
  } step_e;
endpackage

// File: rtl/vagc_peak.sv
module vagc_peak #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          win,
  input  logic          clr,
  input  logic [DW-1:0] smp,
  output logic [DW-1:0] peak
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      peak <= '0;
    end else if (win && (smp > peak)) begin
      peak <= smp;
    end
  end
endmodule

// File: rtl/vagc_regs.sv
module vagc_regs
  import vagc_pkg::*;
#(
  parameter int CW   = 4,
  parameter int FW   = 12,
  parameter int SW   = 8,
  parameter int DLW  = 8,
  parameter int NREF = 4,
  localparam int RW  = CW + FW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [2:0]      addr,
  input  logic [RW-1:0]   wdata,
  input  logic [CW-1:0]   cur_coarse,
  input  logic [FW-1:0]   cur_fine,
  output logic            agc_en,
  output logic [NREF-1:0] ref_en,
  output logic [SW-1:0]   speed,
  output logic [DLW-1:0]  delay,
  output logic [CW-1:0]   man_coarse,
  output logic [FW-1:0]   man_fine,
  output logic [RW-1:0]   rdata
);
  localparam logic [CW-1:0] COARSE_MID = CW'(2 ** (CW - 1));
  localparam logic [FW-1:0] FINE_MID   = FW'(2 ** (FW - 1));

  logic [NREF:0] ctrl_q;

  assign agc_en = ctrl_q[0];
  assign ref_en = ctrl_q[NREF:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      speed      <= SW'(1);
      delay      <= '0;
      man_coarse <= COARSE_MID;
      man_fine   <= FINE_MID;
    end else if (we) begin
      case (addr)
        ADDR_CTRL:   ctrl_q <= wdata[NREF:0];
        ADDR_SPEED:  speed  <= wdata[SW-1:0];
        ADDR_DELAY:  delay  <= wdata[DLW-1:0];
        ADDR_MANUAL: begin
          man_coarse <= wdata[RW-1:FW];
          man_fine   <= wdata[FW-1:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        ADDR_CTRL:   rdata <= RW'(ctrl_q);
        ADDR_SPEED:  rdata <= RW'(speed);
        ADDR_DELAY:  rdata <= RW'(delay);
        ADDR_MANUAL: rdata <= {man_coarse, man_fine};
        ADDR_GAIN:   rdata <= {cur_coarse, cur_fine};
        default:     rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/vagc_law.sv
module vagc_law
  import vagc_pkg::*;
#(
  parameter int DW        = 10,
  parameter int CW        = 4,
  parameter int FW        = 12,
  parameter int SW        = 8,
  parameter int DLW       = 8,
  parameter int NREF      = 4,
  parameter logic [NREF*DW-1:0] TARGETS = '0,
  parameter int DEC_SMALL = 16,
  parameter int DEC_CLIP  = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_end,
  input  logic              agc_en,
  input  logic [NREF-1:0]   ref_en,
  input  logic [NREF*DW-1:0] peaks,
  input  logic [SW-1:0]     speed,
  input  logic [DLW-1:0]    delay,
  input  logic [CW-1:0]     man_coarse,
  input  logic [FW-1:0]     man_fine,
  output logic [CW-1:0]     coarse,
  output logic [FW-1:0]     fine,
  output logic              clip_line
);
  localparam int SUMW = FW + 2;
  localparam logic [DW-1:0]          CLIP_CODE = DW'(2 ** DW - 1);
  localparam logic signed [SUMW-1:0] FINE_MAX  = SUMW'(2 ** FW - 1);
  localparam logic [FW-1:0]          FINE_MID  = FW'(2 ** (FW - 1));
  localparam logic [CW-1:0]          COARSE_MAX = CW'(2 ** CW - 1);
  localparam logic signed [SUMW-1:0] D_SMALL   = SUMW'(DEC_SMALL);
  localparam logic signed [SUMW-1:0] D_CLIP    = SUMW'(DEC_CLIP);
  localparam logic [DLW-1:0]         CNT_MAX   = '1;

  logic [NREF-1:0] clip_v, over_v, under_v;

  for (genvar i = 0; i < NREF; i++) begin : g_ref
    logic [DW-1:0] pk, tg;
    assign pk = peaks[i*DW +: DW];
    assign tg = TARGETS[i*DW +: DW];
    assign clip_v[i]  = ref_en[i] && (pk >= CLIP_CODE);
    assign over_v[i]  = ref_en[i] && (pk > tg);
    assign under_v[i] = !ref_en[i] || (pk < tg);
  end

  logic [DLW-1:0] quiet_cnt;
  logic           any_en;
  step_e          step;
  logic signed [SUMW-1:0] delta, sum;
  logic [CW-1:0]  coarse_nx;
  logic [FW-1:0]  fine_nx;

  assign any_en    = |ref_en;
  assign clip_line = |clip_v;

  always_comb begin
    if (!any_en)                              step = STEP_HOLD;
    else if (clip_line)                       step = STEP_CLIP;
    else if (|over_v)                         step = STEP_DOWN;
    else if ((&under_v) && quiet_cnt >= delay) step = STEP_UP;
    else                                      step = STEP_HOLD;
  end

  always_comb begin
    case (step)
      STEP_CLIP: delta = -D_CLIP;
      STEP_DOWN: delta = -D_SMALL;
      STEP_UP:   delta = $signed(SUMW'(speed));
      default:   delta = '0;
    endcase
    sum       = $signed(SUMW'(fine)) + delta;
    coarse_nx = coarse;
    fine_nx   = sum[FW-1:0];
    if (sum > FINE_MAX) begin
      if (coarse != COARSE_MAX) begin
        coarse_nx = coarse + 1'b1;
        fine_nx   = FINE_MID;
      end else begin
        fine_nx   = FINE_MAX[FW-1:0];
      end
    end else if (sum < 0) begin
      if (coarse != '0) begin
        coarse_nx = coarse - 1'b1;
        fine_nx   = FINE_MID;
      end else begin
        fine_nx   = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      coarse    <= man_coarse;
      fine      <= man_fine;
      quiet_cnt <= '0;
    end else if (!agc_en) begin
      coarse    <= man_coarse;
      fine      <= man_fine;
      quiet_cnt <= '0;
    end else if (line_end && any_en) begin
      coarse <= coarse_nx;
      fine   <= fine_nx;
      if (clip_line)              quiet_cnt <= '0;
      else if (quiet_cnt != CNT_MAX) quiet_cnt <= quiet_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/vagc_top.sv
module vagc_top
  import vagc_pkg::*;
#(
  parameter int DW        = 10,
  parameter int CW        = 4,
  parameter int FW        = 12,
  parameter int SW        = 8,
  parameter int DLW       = 8,
  parameter logic [4*DW-1:0] TARGETS = {10'd900, 10'd1000, 10'd150, 10'd200},
  parameter int DEC_SMALL = 16,
  parameter int DEC_CLIP  = 512,
  localparam int NREF     = 4,
  localparam int RW       = CW + FW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] sample,
  input  logic [DW-1:0] luma,
  input  logic          sync_win,
  input  logic          burst_win,
  input  logic          active_win,
  input  logic          line_end,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  output logic [CW-1:0] coarse_gain,
  output logic [FW-1:0] fine_gain
);
  logic            agc_en, clip_line;
  logic [NREF-1:0] ref_en;
  logic [SW-1:0]   speed;
  logic [DLW-1:0]  delay;
  logic [CW-1:0]   man_coarse;
  logic [FW-1:0]   man_fine;

  logic [NREF-1:0]    win_v;
  logic [NREF*DW-1:0] smp_v, peaks;

  assign win_v = {active_win, active_win, burst_win, sync_win};
  assign smp_v = {luma, sample, sample, sample};

  for (genvar i = 0; i < NREF; i++) begin : g_meas
    vagc_peak #(.DW(DW)) u_peak (
      .clk  (clk),
      .rst  (rst),
      .win  (win_v[i]),
      .clr  (line_end),
      .smp  (smp_v[i*DW +: DW]),
      .peak (peaks[i*DW +: DW])
    );
  end

  vagc_regs #(.CW(CW), .FW(FW), .SW(SW), .DLW(DLW), .NREF(NREF)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .we         (reg_we),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .cur_coarse (coarse_gain),
    .cur_fine   (fine_gain),
    .agc_en     (agc_en),
    .ref_en     (ref_en),
    .speed      (speed),
    .delay      (delay),
    .man_coarse (man_coarse),
    .man_fine   (man_fine),
    .rdata      (reg_rdata)
  );

  vagc_law #(
    .DW(DW), .CW(CW), .FW(FW), .SW(SW), .DLW(DLW), .NREF(NREF),
    .TARGETS(TARGETS), .DEC_SMALL(DEC_SMALL), .DEC_CLIP(DEC_CLIP)
  ) u_law (
    .clk        (clk),
    .rst        (rst),
    .line_end   (line_end),
    .agc_en     (agc_en),
    .ref_en     (ref_en),
    .peaks      (peaks),
    .speed      (speed),
    .delay      (delay),
    .man_coarse (man_coarse),
    .man_fine   (man_fine),
    .coarse     (coarse_gain),
    .fine       (fine_gain),
    .clip_line  (clip_line)
  );
endmodule

// File: rtl/vagc_chk.sv
module vagc_chk #(
  parameter int CW = 4,
  parameter int FW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          line_end,
  input logic          agc_en,
  input logic          clip_line,
  input logic [CW-1:0] man_coarse,
  input logic [FW-1:0] man_fine,
  input logic [CW-1:0] coarse,
  input logic [FW-1:0] fine
);
  localparam logic [FW-1:0] FINE_MID = FW'(2 ** (FW - 1));

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R4: with the loop running, gain moves only right after an end-of-line pulse
  assert_gain_steady_R4: assert property (@(posedge clk) disable iff (rst)
    armed && $past(agc_en) && !$past(line_end) |-> $stable({coarse, fine}));

  // R5: a clipping line never leaves the gain higher or equal, unless it is already at its minimum
  assert_clip_cuts_R5: assert property (@(posedge clk) disable iff (rst)
    armed && $past(agc_en && line_end && clip_line) |->
      (({coarse, fine} < $past({coarse, fine})) || ({coarse, fine} == '0)));

  // R3: with the loop off, the outputs follow the manual register
  assert_manual_follow_R3: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(agc_en) |-> (coarse == $past(man_coarse)) && (fine == $past(man_fine)));

  // R9: a coarse step under loop control re-centres the fine code
  assert_recentre_R9: assert property (@(posedge clk) disable iff (rst)
    armed && $past(agc_en) && (coarse != $past(coarse)) |-> (fine == FINE_MID));

  // R9: the coarse code moves by at most one per step
  assert_coarse_unit_R9: assert property (@(posedge clk) disable iff (rst)
    armed && $past(agc_en) |->
      ((coarse == $past(coarse)) || (coarse == $past(coarse) + 1'b1) ||
       (coarse == $past(coarse) - 1'b1)));
endmodule

bind vagc_top vagc_chk #(.CW(CW), .FW(FW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .line_end   (line_end),
  .agc_en     (agc_en),
  .clip_line  (clip_line),
  .man_coarse (man_coarse),
  .man_fine   (man_fine),
  .coarse     (coarse_gain),
  .fine       (fine_gain)
);

// File: tb/tb_vagc_top.sv
`timescale 1ns/1ps
module tb_vagc_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [9:0]  sample, luma;
  logic        sync_win, burst_win, active_win, line_end;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [3:0]  coarse_gain;
  logic [11:0] fine_gain;

  always #5 clk = ~clk;

  vagc_top dut (
    .clk(clk), .rst(rst), .sample(sample), .luma(luma),
    .sync_win(sync_win), .burst_win(burst_win), .active_win(active_win),
    .line_end(line_end), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .coarse_gain(coarse_gain), .fine_gain(fine_gain)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  // model state
  int mc, mf, mcnt, men, mmask, mspeed, mdelay, manc, manf;
  int lfsr = 32'h1ace;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_gain(input string req);
    chk({req, " coarse"}, int'(coarse_gain), mc);
    chk({req, " fine"}, int'(fine_gain), mf);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_we = 1; reg_addr = 3'(a); reg_wdata = 16'(d);
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); reg_addr = 3'(a);
    @(negedge clk); v = int'(reg_rdata);
  endtask

  task automatic set_ctrl(input int en, input int mask);
    wr(0, (mask << 1) | en);
    men = en; mmask = mask;
    if (en == 0) begin mc = manc; mf = manf; mcnt = 0; end
  endtask

  task automatic set_manual(input int c, input int f);
    wr(3, (c << 12) | f);
    @(negedge clk);
    manc = c; manf = f;
    if (men == 0) begin mc = c; mf = f; end
  endtask

  task automatic set_rate(input int sp, input int dl);
    wr(1, sp); wr(2, dl); mspeed = sp; mdelay = dl;
  endtask

  // expected behaviour from the requirements
  task automatic model(input int p0, input int p1, input int p2, input int p3);
    int p[4], tg[4], d, s;
    bit clip, over, under;
    p = '{p0, p1, p2, p3};
    tg = '{200, 150, 1000, 900};
    if (men == 0) begin mc = manc; mf = manf; mcnt = 0; return; end
    if (mmask == 0) return;
    clip = 0; over = 0; under = 1;
    for (int i = 0; i < 4; i++) begin
      if (mmask[i]) begin
        if (p[i] >= 1023) clip = 1;
        if (p[i] > tg[i]) over = 1;
        if (!(p[i] < tg[i])) under = 0;
      end
    end
    d = 0;
    if (clip) d = -512;
    else if (over) d = -16;
    else if (under && mcnt >= mdelay) d = mspeed;
    if (clip) mcnt = 0; else if (mcnt < 255) mcnt++;
    s = mf + d;
    if (s > 4095) begin
      if (mc < 15) begin mc++; mf = 2048; end else mf = 4095;
    end else if (s < 0) begin
      if (mc > 0) begin mc--; mf = 2048; end else mf = 0;
    end else mf = s;
  endtask

  task automatic cyc(input int s, input int l, input bit sw, input bit bw,
                     input bit aw, input bit le);
    @(negedge clk);
    sample = 10'(s); luma = 10'(l);
    sync_win = sw; burst_win = bw; active_win = aw; line_end = le;
  endtask

  task automatic run_line(input int p0, input int p1, input int p2, input int p3);
    cyc(p0 / 2, 1023, 1, 0, 0, 0);
    cyc(p0, 0, 1, 0, 0, 0);
    cyc(p0 / 3, 1023, 1, 0, 0, 0);
    cyc(1023, 1023, 0, 0, 0, 0);
    cyc(p1 / 2, 0, 0, 1, 0, 0);
    cyc(p1, 1023, 0, 1, 0, 0);
    cyc(p1 / 4, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    cyc(p2 / 2, p3, 0, 0, 1, 0);
    cyc(p2, p3 / 2, 0, 0, 1, 0);
    cyc(p2 / 4, p3 / 3, 0, 0, 1, 0);
    cyc(1023, 1023, 0, 0, 0, 0);
    cyc(1023, 1023, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0);
    model(p0, p1, p2, p3);
  endtask

  function automatic int pick(input int tgt, input int sel);
    case (sel)
      0, 1, 6: return tgt - 30 - sel;
      2:       return tgt / 2;
      3:       return tgt;
      4, 5:    return (tgt + 20 > 1022) ? 1022 : tgt + 20;
      default: return 1023;
    endcase
  endfunction

  function automatic int step_lfsr(input int v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  initial begin
    int v;
    rst = 1; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    sample = 0; luma = 0; sync_win = 0; burst_win = 0; active_win = 0; line_end = 0;
    men = 0; mmask = 0; mspeed = 1; mdelay = 0; manc = 8; manf = 2048;
    mc = 8; mf = 2048; mcnt = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    chk("R1 reset gain", int'({coarse_gain, fine_gain}), 16'h8800);
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 speed", v, 1);
    rd(2, v); chk("R1 delay", v, 0);
    rd(3, v); chk("R2 manual readback", v, 16'h8800);

    // R2/R3 manual gain while disabled
    set_manual(3, 100);
    chk_gain("R3 manual applied");
    rd(4, v); chk("R2 gain-in-use readback", v, 16'h3064);
    run_line(1023, 1023, 1023, 1023);
    chk_gain("R3 line ignored while disabled");

    // R5/R6/R7 directed steps, all references, delay 0, speed 1
    set_manual(4, 1000);
    set_rate(1, 0);
    set_ctrl(1, 15);
    rd(0, v); chk("R2 ctrl readback", v, 31);
    run_line(100, 100, 1023, 100);
    chk("R5 clip cut", int'(fine_gain), 488); chk_gain("R5 clip");
    run_line(250, 100, 900, 800);
    chk("R6 over-target cut", int'(fine_gain), 472); chk_gain("R6 over");
    run_line(100, 100, 900, 800);
    chk("R7 rise", int'(fine_gain), 473); chk_gain("R7 rise");
    run_line(200, 100, 900, 800);
    chk("R7 equal holds", int'(fine_gain), 473); chk_gain("R7 hold");

    // R8/R9 clip clears count, borrow, then delayed rise
    set_rate(1, 2);
    run_line(100, 100, 900, 1023);
    chk("R9 borrow coarse", int'(coarse_gain), 3);
    chk("R9 borrow fine", int'(fine_gain), 2048);
    run_line(100, 100, 900, 800); chk("R8 delay line 1", int'(fine_gain), 2048);
    run_line(100, 100, 900, 800); chk("R8 delay line 2", int'(fine_gain), 2048);
    run_line(100, 100, 900, 800); chk("R8 delay expired", int'(fine_gain), 2049);

    // R11 disabled references ignored, empty mask holds
    set_ctrl(1, 1);
    run_line(100, 1023, 1023, 1023);
    chk("R11 masked clip ignored", int'(fine_gain), 2050); chk_gain("R11 mask");
    set_ctrl(1, 0);
    run_line(1023, 1023, 1023, 1023);
    chk_gain("R11 empty mask holds");

    // R9 carry, R10 saturation
    set_ctrl(0, 0);
    set_manual(5, 4000);
    set_rate(200, 0);
    set_ctrl(1, 15);
    run_line(100, 100, 900, 800);
    chk("R9 carry coarse", int'(coarse_gain), 6);
    chk("R9 carry fine", int'(fine_gain), 2048);
    set_ctrl(0, 0);
    set_manual(15, 4000);
    set_rate(255, 0);
    set_ctrl(1, 15);
    run_line(100, 100, 900, 800);
    chk("R10 top saturate", int'({coarse_gain, fine_gain}), 16'hFFFF);
    set_ctrl(0, 0);
    set_manual(0, 300);
    set_ctrl(1, 15);
    run_line(1023, 100, 900, 800);
    chk("R10 bottom saturate", int'({coarse_gain, fine_gain}), 0);

    // sweep: every mask, two delays, two speeds, pseudo-random peaks
    for (int m = 0; m < 16; m++) begin
      for (int dl = 0; dl < 2; dl++) begin
        for (int sp = 0; sp < 2; sp++) begin
          set_ctrl(0, 0);
          set_manual(8, 2048);
          set_rate(sp ? 200 : 1, dl ? 3 : 0);
          set_ctrl(1, m);
          for (int n = 0; n < 24; n++) begin
            int q0, q1, q2, q3;
            lfsr = step_lfsr(lfsr); q0 = pick(200, lfsr & 7);
            lfsr = step_lfsr(lfsr); q1 = pick(150, lfsr & 7);
            lfsr = step_lfsr(lfsr); q2 = pick(1000, lfsr & 7);
            lfsr = step_lfsr(lfsr); q3 = pick(900, lfsr & 7);
            run_line(q0, q1, q2, q3);
            chk_gain("R4 R5 R6 R7 R8 sweep");
          end
          rd(4, v); chk("R2 sweep readback", v, (mc << 12) | mf);
        end
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R4 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule